// File: doc/BRIEF.md
# Banked Nibble-Wide Calendar Clock

This block keeps time of day and date as packed decimal digits and exposes them to a host through a 4-bit data bus with a 4-bit address. Sixteen addresses exist. The top three are always the same registers: the mode register, a scratch test register and the reset/control register. The lower thirteen addresses form a window. The two low bits of the mode register steer that window onto one of four banks: the time digits, the alarm and configuration nibbles, or one of two general-purpose nibble RAMs.

Time is paced by `base_tick_i`, a 16 Hz strobe. A prescaler divides it by `DIV` to form the one-second step. The step ripples through seconds, minutes, hours, weekday, day, month and year. Hours follow either 24-hour or 12-hour counting. February length follows a two-bit leap counter. A timer-enable bit lets the host freeze the digits while it reads or rewrites them. A second that falls due during the freeze is kept and applied when counting resumes.

The register port has no back-pressure. A write is taken at the clock edge on which `bus_cs_i` and `bus_we_i` are both high, so the host may issue one access every cycle. Reads are combinational from `bus_addr_i`.

Top module: `rtc_nibble_clock`

## Requirements
- R1: Register port behaviour.
  - The port has sixteen 4-bit registers. A write occurs on a clock edge where `bus_cs_i` and `bus_we_i` are both 1. `bus_rdata_o` shows the addressed register combinationally.
  - Address 0xD is the mode register and address 0xE is a read/write test register. Both are reachable in every bank.
  - After reset the mode register reads 4'h8, the reset/control register reads 0, the day and month digits read 1 and every other time digit reads 0.
- R2: Mode bits [1:0] pick the bank behind addresses 0x0–0xC.
  - 00 selects the time digits. In address order these are: second units, second tens, minute units, minute tens, hour units, hour tens, weekday, day units, day tens, month units, month tens, year units, year tens.
  - 01 selects the configuration bank. Addresses 0x0–0x9 are alarm nibbles. Bit 0 of 0xA set means 24-hour counting (reset value 1). Bits [1:0] of 0xB are the leap counter. 0xC reads 0.
  - 10 selects RAM bank A and 11 selects RAM bank B. Each holds 13 nibbles, and its contents survive switching to other banks.
- R3: Every `DIV`-th `base_tick_i` pulse produces one second. Writing 1 to bit 1 of address 0xF restarts the divide count from zero.
- R4: Mode bit 3 enables the timer. While it is 0 the digits do not change. One second that falls due in that time is applied exactly once after the bit returns to 1.
- R5: Second and minute units wrap from 9 to 0, and their tens wrap from 5 to 0, each with a carry onward. A digit at or above its wrap value, such as an out-of-range value written by the host, wraps on the next step.
- R6: In 24-hour mode the hour goes from 23 to 00 and carries into the day.
- R7: In 12-hour mode bit 0 of the hour-tens digit is the tens digit and bit 1 is the PM flag.
  - 11 goes to 12 and toggles PM.
  - 12 goes to 1 with PM kept.
  - 11 PM going to 12 AM also carries into the day.
- R8: On a day carry, the weekday counts 0 to 6 and wraps. The day wraps to 01 past the month's last day, with a month carry. April, June, September and November have 30 days. February has 29 days when the leap counter is 0 and 28 otherwise. All other months have 31 days. Months run 1 to 12.
- R9: December rolling into January advances the two-digit year, with 99 wrapping to 00, and increments the leap counter modulo 4.
- R10: Writing 1 to bit 0 of address 0xF clears all ten alarm nibbles.
- R11: Bits 3 and 2 of address 0xF are stored and read back, while bits 1 and 0 read 0.
  - With bit 3 set, `pulse_1hz_o` is high for one cycle per second.
  - With bit 2 set, `pulse_16hz_o` is high for one cycle per base tick.
  - With a bit clear, its pulse output stays low.
- R12: A write to a time digit stores the written nibble as is, even when it is out of range. A second that falls due in the cycle of such a write is applied on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick_i | input | 1 | 16 Hz strobe, one cycle wide |
| bus_cs_i | input | 1 | Register port select |
| bus_we_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Read data for `bus_addr_i` |
| pulse_1hz_o | output | 1 | Once-per-second pulse, gated by control bit 3 |
| pulse_16hz_o | output | 1 | Base-tick pulse, gated by control bit 2 |

## Verification
The embedded properties assume that `base_tick_i` is a single-cycle strobe and that the host never writes a time digit while expecting the counters to stay frozen. The stimulus keeps to these assumptions in three ways. Every tick is raised for exactly one clock. Time is preloaded only with the timer bit cleared. The divider is restarted before each measured second. It therefore never produces a stray second between preload and check.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NDIG   = 13;
  localparam int NALARM = 10;
  localparam int NRAM   = 13;
  localparam int DW     = 4;

  typedef enum logic [1:0] {
    BANK_TIME = 2'b00,
    BANK_CFG  = 2'b01,
    BANK_RAMA = 2'b10,
    BANK_RAMB = 2'b11
  } bank_e;

  localparam int D_S1 = 0, D_S10 = 1, D_M1 = 2, D_M10 = 3, D_H1 = 4, D_H10 = 5,
                 D_DOW = 6, D_D1 = 7, D_D10 = 8, D_MO1 = 9, D_MO10 = 10,
                 D_Y1 = 11, D_Y10 = 12;

  localparam logic [3:0] A_MODE = 4'hD;
  localparam logic [3:0] A_TEST = 4'hE;
  localparam logic [3:0] A_CTRL = 4'hF;
  localparam logic [3:0] A_H24  = 4'hA;
  localparam logic [3:0] A_LEAP = 4'hB;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o,
  output logic sub_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sec_o <= 1'b0;
      sub_o <= 1'b0;
    end else begin
      sub_o <= tick_i;
      sec_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          sec_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  sec_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o |-> $past(tick_i) && !$past(clr_i));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_i,
  input  logic                wr_i,
  input  logic [3:0]          wr_idx_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                h24_wr_i,
  input  logic                leap_wr_i,
  output logic [NDIG*DW-1:0]  digits_o,
  output logic                h24_o,
  output logic [1:0]          leap_o
);
  logic [DW-1:0] d_q [NDIG];
  logic [DW-1:0] d_n [NDIG];
  logic [1:0]    leap_n;
  logic          c_min, c_hr, c_day, c_mon, c_yr;
  logic          tens, pm;

  function automatic logic [6:0] bcd2bin(input logic [3:0] t, input logic [3:0] o);
    return ({3'b000, t} * 7'd10) + {3'b000, o};
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [1:0] lp);
    case (mon)
      7'd2:                        return (lp == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     return 7'd30;
      default:                     return 7'd31;
    endcase
  endfunction

  always_comb begin
    d_n    = d_q;
    leap_n = leap_o;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    tens = d_q[D_H10][0];
    pm   = d_q[D_H10][1];
    if (step_i) begin
      if (d_q[D_S1] >= 4'd9) begin
        d_n[D_S1] = 4'd0;
        if (d_q[D_S10] >= 4'd5) begin d_n[D_S10] = 4'd0; c_min = 1'b1; end
        else d_n[D_S10] = d_q[D_S10] + 4'd1;
      end else d_n[D_S1] = d_q[D_S1] + 4'd1;

      if (c_min) begin
        if (d_q[D_M1] >= 4'd9) begin
          d_n[D_M1] = 4'd0;
          if (d_q[D_M10] >= 4'd5) begin d_n[D_M10] = 4'd0; c_hr = 1'b1; end
          else d_n[D_M10] = d_q[D_M10] + 4'd1;
        end else d_n[D_M1] = d_q[D_M1] + 4'd1;
      end

      if (c_hr) begin
        if (h24_o) begin
          if (bcd2bin(d_q[D_H10], d_q[D_H1]) >= 7'd23) begin
            d_n[D_H10] = 4'd0; d_n[D_H1] = 4'd0; c_day = 1'b1;
          end else if (d_q[D_H1] >= 4'd9) begin
            d_n[D_H1] = 4'd0; d_n[D_H10] = d_q[D_H10] + 4'd1;
          end else d_n[D_H1] = d_q[D_H1] + 4'd1;
        end else begin
          if (tens && d_q[D_H1] == 4'd1) begin
            d_n[D_H1] = 4'd2; d_n[D_H10] = {2'b00, ~pm, 1'b1}; c_day = pm;
          end else if (tens && d_q[D_H1] >= 4'd2) begin
            d_n[D_H1] = 4'd1; d_n[D_H10] = {2'b00, pm, 1'b0};
          end else if (d_q[D_H1] >= 4'd9) begin
            d_n[D_H1] = 4'd0; d_n[D_H10] = {2'b00, pm, 1'b1};
          end else d_n[D_H1] = d_q[D_H1] + 4'd1;
        end
      end

      if (c_day) begin
        d_n[D_DOW] = (d_q[D_DOW] >= 4'd6) ? 4'd0 : d_q[D_DOW] + 4'd1;
        if (bcd2bin(d_q[D_D10], d_q[D_D1]) >=
            month_len(bcd2bin(d_q[D_MO10], d_q[D_MO1]), leap_o)) begin
          d_n[D_D1] = 4'd1; d_n[D_D10] = 4'd0; c_mon = 1'b1;
        end else if (d_q[D_D1] >= 4'd9) begin
          d_n[D_D1] = 4'd0; d_n[D_D10] = d_q[D_D10] + 4'd1;
        end else d_n[D_D1] = d_q[D_D1] + 4'd1;
      end

      if (c_mon) begin
        if (bcd2bin(d_q[D_MO10], d_q[D_MO1]) >= 7'd12) begin
          d_n[D_MO1] = 4'd1; d_n[D_MO10] = 4'd0; c_yr = 1'b1;
        end else if (d_q[D_MO1] >= 4'd9) begin
          d_n[D_MO1] = 4'd0; d_n[D_MO10] = 4'd1;
        end else d_n[D_MO1] = d_q[D_MO1] + 4'd1;
      end

      if (c_yr) begin
        leap_n = leap_o + 2'd1;
        if (d_q[D_Y1] >= 4'd9) begin
          d_n[D_Y1] = 4'd0;
          d_n[D_Y10] = (d_q[D_Y10] >= 4'd9) ? 4'd0 : d_q[D_Y10] + 4'd1;
        end else d_n[D_Y1] = d_q[D_Y1] + 4'd1;
      end
    end
    if (wr_i && (wr_idx_i < 4'(NDIG))) d_n[wr_idx_i] = wr_data_i;
    if (leap_wr_i) leap_n = wr_data_i[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDIG; i++) d_q[i] <= 4'd0;
      d_q[D_D1]  <= 4'd1;
      d_q[D_MO1] <= 4'd1;
      leap_o     <= 2'd0;
      h24_o      <= 1'b1;
    end else begin
      for (int i = 0; i < NDIG; i++) d_q[i] <= d_n[i];
      leap_o <= leap_n;
      if (h24_wr_i) h24_o <= wr_data_i[0];
    end
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_flat
    assign digits_o[g*DW +: DW] = d_q[g];
  end

  // R5
  sec_units_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !wr_i) |=> d_q[D_S1] <= 4'd9);

  // R9
  leap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !leap_wr_i) |=> $stable(leap_o));
endmodule

// File: rtl/rtc_nibble_clock.sv
module rtc_nibble_clock
  import rtc_pkg::*;
#(
  parameter int DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick_i,
  input  logic       bus_cs_i,
  input  logic       bus_we_i,
  input  logic [3:0] bus_addr_i,
  input  logic [3:0] bus_wdata_i,
  output logic [3:0] bus_rdata_o,
  output logic       pulse_1hz_o,
  output logic       pulse_16hz_o
);
  logic [3:0]          mode_q, test_q;
  logic [1:0]          pen_q;
  logic [DW-1:0]       alarm_q [NALARM];
  logic [DW-1:0]       ram_a_q [NRAM];
  logic [DW-1:0]       ram_b_q [NRAM];
  logic                pend_q;
  logic                wr, in_win, time_wr, cfg_sel, ctrl_wr, alarm_clr;
  logic                sec, sub, step;
  logic [NDIG*DW-1:0]  dig_flat;
  logic                h24;
  logic [1:0]          leap;
  bank_e               bank;

  assign bank      = bank_e'(mode_q[1:0]);
  assign wr        = bus_cs_i && bus_we_i;
  assign in_win    = bus_addr_i < 4'(NDIG);
  assign time_wr   = wr && in_win && (bank == BANK_TIME);
  assign cfg_sel   = wr && (bank == BANK_CFG);
  assign ctrl_wr   = wr && (bus_addr_i == A_CTRL);
  assign alarm_clr = ctrl_wr && bus_wdata_i[0];
  assign step      = (sec || pend_q) && mode_q[3] && !time_wr;

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_i(base_tick_i),
    .clr_i(ctrl_wr && bus_wdata_i[1]), .sec_o(sec), .sub_o(sub)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step_i(step),
    .wr_i(time_wr), .wr_idx_i(bus_addr_i), .wr_data_i(bus_wdata_i),
    .h24_wr_i(cfg_sel && bus_addr_i == A_H24),
    .leap_wr_i(cfg_sel && bus_addr_i == A_LEAP),
    .digits_o(dig_flat), .h24_o(h24), .leap_o(leap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 4'h8;
      test_q <= 4'h0;
      pen_q  <= 2'b00;
      pend_q <= 1'b0;
      for (int i = 0; i < NALARM; i++) alarm_q[i] <= '0;
      for (int i = 0; i < NRAM; i++) begin
        ram_a_q[i] <= '0;
        ram_b_q[i] <= '0;
      end
    end else begin
      pend_q <= step ? (sec && pend_q) : (sec || pend_q);
      if (wr && bus_addr_i == A_MODE) mode_q <= bus_wdata_i;
      if (wr && bus_addr_i == A_TEST) test_q <= bus_wdata_i;
      if (ctrl_wr) pen_q <= bus_wdata_i[3:2];
      if (alarm_clr) begin
        for (int i = 0; i < NALARM; i++) alarm_q[i] <= '0;
      end else if (cfg_sel && bus_addr_i < 4'(NALARM)) begin
        alarm_q[bus_addr_i] <= bus_wdata_i;
      end
      if (wr && in_win && bank == BANK_RAMA) ram_a_q[bus_addr_i] <= bus_wdata_i;
      if (wr && in_win && bank == BANK_RAMB) ram_b_q[bus_addr_i] <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = 4'h0;
    case (bus_addr_i)
      A_MODE: bus_rdata_o = mode_q;
      A_TEST: bus_rdata_o = test_q;
      A_CTRL: bus_rdata_o = {pen_q, 2'b00};
      default: begin
        case (bank)
          BANK_TIME: bus_rdata_o = dig_flat[{bus_addr_i, 2'b00} +: DW];
          BANK_CFG: begin
            if (bus_addr_i < 4'(NALARM))    bus_rdata_o = alarm_q[bus_addr_i];
            else if (bus_addr_i == A_H24)   bus_rdata_o = {3'b000, h24};
            else if (bus_addr_i == A_LEAP)  bus_rdata_o = {2'b00, leap};
          end
          BANK_RAMA: bus_rdata_o = ram_a_q[bus_addr_i];
          BANK_RAMB: bus_rdata_o = ram_b_q[bus_addr_i];
          default:   bus_rdata_o = 4'h0;
        endcase
      end
    endcase
  end

  assign pulse_1hz_o  = sec && pen_q[1];
  assign pulse_16hz_o = sub && pen_q[0];

  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[3] && !time_wr) |=> $stable(dig_flat));

  // R4
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mode_q[3] && !time_wr && !sec) |=> !pend_q);

  // R10
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr |=> (alarm_q[0] == '0 && alarm_q[4] == '0 && alarm_q[NALARM-1] == '0));

  // R12
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec && time_wr) |=> pend_q);
endmodule

// File: tb/rtc_nibble_clock_bench.sv
module rtc_nibble_clock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'h0, wdata = 4'h0;
  logic [3:0] rdata;
  logic p1, p16;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_nibble_clock u_rtc_nibble_clock (
    .clk(clk), .rst_n(rst_n), .base_tick_i(base_tick),
    .bus_cs_i(cs), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .pulse_1hz_o(p1), .pulse_16hz_o(p16)
  );

  // {h24, leap_in, start digits (10-year .. 1-second), expected digits, leap_out}
  localparam logic [108:0] VEC [12] = '{
    {1'b1, 2'd0, 52'h2305142102030, 52'h2305142102031, 2'd0},
    {1'b1, 2'd0, 52'h2305142102959, 52'h2305142103000, 2'd0},
    {1'b1, 2'd0, 52'h2301316235959, 52'h2302010000000, 2'd0},
    {1'b1, 2'd0, 52'h2402286235959, 52'h2402290000000, 2'd0},
    {1'b1, 2'd1, 52'h2302283235959, 52'h2303014000000, 2'd1},
    {1'b1, 2'd0, 52'h2304305235959, 52'h2305016000000, 2'd0},
    {1'b1, 2'd3, 52'h9912311235959, 52'h0001012000000, 2'd0},
    {1'b1, 2'd0, 52'h2309300235959, 52'h2310011000000, 2'd0},
    {1'b0, 2'd0, 52'h2305142115959, 52'h2305142320000, 2'd0},
    {1'b0, 2'd0, 52'h2301311315959, 52'h2302012120000, 2'd0},
    {1'b0, 2'd0, 52'h2305142325959, 52'h2305142210000, 2'd0},
    {1'b1, 2'd0, 52'h230514210000C, 52'h2305142100010, 2'd0}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:        return "R5";
      2:           return "R6";
      3, 4, 5, 7:  return "R8";
      6:           return "R9";
      8, 9, 10:    return "R7";
      default:     return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    logic [51:0] got;
    int c1, c16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'hD, v); check("R1 mode reset", v, 4'h8);
    rd(4'hF, v); check("R1 ctrl reset", v, 4'h0);
    rd(4'h0, v); check("R1 s1 reset", v, 4'h0);
    rd(4'h7, v); check("R1 day reset", v, 4'h1);
    rd(4'h9, v); check("R1 month reset", v, 4'h1);
    check("R11 pulses idle", {p1, p16}, 2'b00);
    wr(4'hE, 4'h6); rd(4'hE, v); check("R1 test reg", v, 4'h6);

    // calendar vectors
    for (int i = 0; i < 12; i++) begin
      wr(4'hD, 4'b0001);
      wr(4'hA, {3'b000, VEC[i][108]});
      wr(4'hB, {2'b00, VEC[i][107:106]});
      wr(4'hD, 4'b0000);
      for (int j = 0; j < 13; j++) wr(4'(j), VEC[i][54 + j*4 +: 4]);
      wr(4'hF, 4'b0010);
      wr(4'hD, 4'b1000);
      ticks(16);
      repeat (2) @(negedge clk);
      for (int j = 0; j < 13; j++) begin
        rd(4'(j), v);
        got[j*4 +: 4] = v;
      end
      check(vtag(i), got, VEC[i][53:2]);
      wr(4'hD, 4'b1001);
      rd(4'hB, v); check("R9 leap counter", v, {2'b00, VEC[i][1:0]});
      wr(4'hD, 4'b1000);
    end

    // R12 out-of-range write stored as is
    wr(4'h0, 4'hC); rd(4'h0, v); check("R12 raw store", v, 4'hC);

    // R3 divider restart
    wr(4'h0, 4'h2); wr(4'hF, 4'b0010);
    ticks(10); wr(4'hF, 4'b0010); ticks(10);
    repeat (2) @(negedge clk);
    rd(4'h0, v); check("R3 restart holds", v, 4'h2);
    ticks(6); repeat (2) @(negedge clk);
    rd(4'h0, v); check("R3 second after DIV ticks", v, 4'h3);

    // R4 freeze and pending second
    wr(4'hD, 4'b0000); wr(4'h0, 4'h3); wr(4'hF, 4'b0010);
    ticks(32); repeat (3) @(negedge clk);
    rd(4'h0, v); check("R4 frozen", v, 4'h3);
    wr(4'hD, 4'b1000); repeat (3) @(negedge clk);
    rd(4'h0, v); check("R4 pending applied once", v, 4'h4);

    // R2 RAM banks
    wr(4'hD, 4'b1010); wr(4'h3, 4'h5); wr(4'hC, 4'h9);
    wr(4'hD, 4'b1011); wr(4'h3, 4'hA);
    wr(4'hD, 4'b1000);
    wr(4'hD, 4'b1010);
    rd(4'h3, v); check("R2 ram A addr3", v, 4'h5);
    rd(4'hC, v); check("R2 ram A addr12", v, 4'h9);
    wr(4'hD, 4'b1011);
    rd(4'h3, v); check("R2 ram B addr3", v, 4'hA);
    rd(4'hD, v); check("R2 mode visible", v, 4'hB);

    // R10 alarm clear
    wr(4'hD, 4'b1001); wr(4'h4, 4'h7);
    rd(4'h4, v); check("R10 alarm stored", v, 4'h7);
    rd(4'hC, v); check("R2 cfg addr12", v, 4'h0);
    wr(4'hF, 4'b0001);
    rd(4'h4, v); check("R10 alarm cleared", v, 4'h0);
    wr(4'hD, 4'b1000);

    // R11 pulse outputs
    wr(4'hF, 4'b1110);
    rd(4'hF, v); check("R11 ctrl readback", v, 4'b1100);
    c1 = 0; c16 = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
      c1 += int'(p1); c16 += int'(p16);
    end
    check("R11 16Hz count", c16, 16);
    check("R11 1Hz count", c1, 1);
    wr(4'hF, 4'b0010);
    c1 = 0; c16 = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
      c1 += int'(p1); c16 += int'(p16);
    end
    check("R11 pulses gated off", c1 + c16, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule